// File: doc/BRIEF.md
# Tagged pointer subtract-and-compare execution unit

This unit decodes one 32-bit instruction word and, when the word is its own, subtracts two tagged 64-bit pointers and produces the condition flags. Only the low 56 address bits of each pointer take part. Each operand is sign-extended from bit 55 before the subtraction, so tag bits in the top byte never affect the difference. Either source index may name the stack pointer.

The surrounding pipeline presents the word, the two register values it has already read, the current stack pointer and a feature-enable input, all qualified by a valid strobe. One clock later the unit returns the 64-bit difference, the destination index, a register write enable, the four flags with their own write enable, and three classification outputs: undefined, not-mine and compare-alias. The register file, hazards and trap handling belong to the surrounding pipeline.

Top module: `ptr_sub_flags_unit`

## Requirements
- R1: A word belongs to the unit when bits 31:21 equal 10111010110 and bits 15:10 are all zero. The second-source index is in bits 20:16, the first-source index in bits 9:5 and the destination index in bits 4:0. rd_idx_o carries bits 4:0 of the captured word.
- R2: A source index of 31 selects sp_i instead of the supplied register value. This applies separately to the first operand (bits 9:5) and to the second operand (bits 20:16).
- R3: Bits 63:56 of each operand are discarded, and bit 55 is copied into bits 63:56 before the arithmetic.
- R4: res_o equals the first extended operand minus the second extended operand, modulo 2^64.
- R5: flags_o is {N,Z,C,V} with N at bit 3 and V at bit 0. N is res_o bit 63. Z is set when res_o is zero. C is the carry out of first + ~second + 1, which is 1 when the first extended operand is unsigned greater than or equal to the second. V is signed overflow of the 64-bit subtraction.
- R6: For a matching word with tag_en_i low, undef_o is 1 and both rd_we_o and flags_we_o are 0.
- R7: For a matching word with destination index 31, rd_we_o is 0 and cmp_alias_o is 1. If tag_en_i is high, flags_we_o is 1.
- R8: For a non-matching word, not_mine_o is 1, and rd_we_o, flags_we_o, undef_o and cmp_alias_o are 0.
- R9: Outputs appear on the clock edge that follows a cycle with in_valid_i high. After a cycle with in_valid_i low, out_valid_o and every enable and classification output are 0.
- R10: rst_ni low clears out_valid_o and all enable and classification outputs, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input word and operands are valid |
| insn_i | input | 32 | Instruction word |
| rn_val_i | input | 64 | Value of the register named by bits 9:5 |
| rm_val_i | input | 64 | Value of the register named by bits 20:16 |
| sp_i | input | 64 | Current stack pointer |
| tag_en_i | input | 1 | Memory-tagging feature enable |
| out_valid_o | output | 1 | Registered outputs are valid |
| res_o | output | 64 | Difference |
| rd_idx_o | output | 5 | Destination register index |
| rd_we_o | output | 1 | General-register write enable |
| flags_o | output | 4 | {N,Z,C,V} |
| flags_we_o | output | 1 | Flag write enable |
| undef_o | output | 1 | Matching word while the feature is disabled |
| not_mine_o | output | 1 | Word is not this unit's encoding |
| cmp_alias_o | output | 1 | Word is the compare form (result discarded) |

## Verification
Every output is a single register stage, so a fault in decode, operand selection or the adder shows at the ports on the edge right after the valid cycle. A wrong decode appears as a swapped not_mine_o or undef_o, or as a write enable set for the zero register. A fault in the upper-bit masking or in stack pointer selection shows as a difference that depends on tag bits, or that uses the register value when the index is 31. A broken carry or zero path shows as a flag nibble that disagrees with the difference on the same edge.

// File: rtl/ptr_sub_pkg.sv
package ptr_sub_pkg;
  localparam int unsigned IDX_W  = 5;
  localparam int unsigned INSN_W = 32;
  localparam logic [10:0] OPC_HI = 11'b10111010110;  // bits 31:21
  localparam logic [IDX_W-1:0] SP_ZR_IDX = '1;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;
endpackage

// File: rtl/ptrsub_decode.sv
module ptrsub_decode
  import ptr_sub_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  rn_idx_o,
  output logic [IDX_W-1:0]  rm_idx_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  output logic              s_bit_o
);
  assign hit_o    = (insn_i[31:21] == OPC_HI) && (insn_i[15:10] == 6'd0);
  assign rm_idx_o = insn_i[20:16];
  assign rn_idx_o = insn_i[9:5];
  assign rd_idx_o = insn_i[4:0];
  assign s_bit_o  = insn_i[29];
endmodule

// File: rtl/ptrsub_opsel.sv
module ptrsub_opsel
  import ptr_sub_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [XLEN-1:0]  reg_i,
  input  logic [XLEN-1:0]  sp_i,
  output logic [XLEN-1:0]  op_o
);
  // index 31 names the stack pointer on source ports
  assign op_o = (idx_i == SP_ZR_IDX) ? sp_i : reg_i;
endmodule

// File: rtl/ptrsub_alu.sv
module ptrsub_alu
  import ptr_sub_pkg::*;
#(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned ADDR_W = 56
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] res_o,
  output nzcv_t           flags_o
);
  localparam int unsigned EXT_W = XLEN - ADDR_W;

  logic [XLEN-1:0] a_ext, b_inv;
  logic [XLEN:0]   sum;
  logic            unused_tag;

  assign unused_tag = ^{a_i[XLEN-1:ADDR_W], b_i[XLEN-1:ADDR_W]};
  assign a_ext = {{EXT_W{a_i[ADDR_W-1]}}, a_i[ADDR_W-1:0]};
  assign b_inv = ~{{EXT_W{b_i[ADDR_W-1]}}, b_i[ADDR_W-1:0]};
  assign sum   = {1'b0, a_ext} + {1'b0, b_inv} + {{XLEN{1'b0}}, 1'b1};
  assign res_o = sum[XLEN-1:0];

  always_comb begin
    flags_o.n = sum[XLEN-1];
    flags_o.z = (sum[XLEN-1:0] == '0);
    flags_o.c = sum[XLEN];
    flags_o.v = (a_ext[XLEN-1] == b_inv[XLEN-1]) && (sum[XLEN-1] != a_ext[XLEN-1]);
  end
endmodule

// File: rtl/ptr_sub_flags_unit.sv
module ptr_sub_flags_unit
  import ptr_sub_pkg::*;
#(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned ADDR_W = 56
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [INSN_W-1:0] insn_i,
  input  logic [XLEN-1:0]   rn_val_i,
  input  logic [XLEN-1:0]   rm_val_i,
  input  logic [XLEN-1:0]   sp_i,
  input  logic              tag_en_i,
  output logic              out_valid_o,
  output logic [XLEN-1:0]   res_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  output logic              rd_we_o,
  output logic [3:0]        flags_o,
  output logic              flags_we_o,
  output logic              undef_o,
  output logic              not_mine_o,
  output logic              cmp_alias_o
);
  logic             hit, s_bit;
  logic [IDX_W-1:0] rd_idx;
  logic [IDX_W-1:0] src_idx [2];
  logic [XLEN-1:0]  src_val [2];
  logic [XLEN-1:0]  src_op  [2];
  logic [XLEN-1:0]  diff;
  nzcv_t            nzcv;

  ptrsub_decode u_dec (
    .insn_i  (insn_i),
    .hit_o   (hit),
    .rn_idx_o(src_idx[0]),
    .rm_idx_o(src_idx[1]),
    .rd_idx_o(rd_idx),
    .s_bit_o (s_bit)
  );

  assign src_val[0] = rn_val_i;
  assign src_val[1] = rm_val_i;

  for (genvar g = 0; g < 2; g++) begin : g_src
    ptrsub_opsel #(.XLEN(XLEN)) u_sel (
      .idx_i(src_idx[g]),
      .reg_i(src_val[g]),
      .sp_i (sp_i),
      .op_o (src_op[g])
    );
  end

  ptrsub_alu #(.XLEN(XLEN), .ADDR_W(ADDR_W)) u_alu (
    .a_i    (src_op[0]),
    .b_i    (src_op[1]),
    .res_o  (diff),
    .flags_o(nzcv)
  );

  logic exec_ok, rd_is_zr;
  assign exec_ok  = in_valid_i && hit && tag_en_i;
  assign rd_is_zr = (rd_idx == SP_ZR_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      rd_we_o     <= 1'b0;
      flags_we_o  <= 1'b0;
      undef_o     <= 1'b0;
      not_mine_o  <= 1'b0;
      cmp_alias_o <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
      rd_we_o     <= exec_ok && !rd_is_zr;
      flags_we_o  <= exec_ok;
      undef_o     <= in_valid_i && hit && !tag_en_i;
      not_mine_o  <= in_valid_i && !hit;
      cmp_alias_o <= in_valid_i && hit && s_bit && rd_is_zr;
    end
  end

  // datapath: no reset needed, qualified by valid and enables
  always_ff @(posedge clk_i) begin
    if (in_valid_i) begin
      res_o    <= diff;
      flags_o  <= nzcv;
      rd_idx_o <= rd_idx;
    end
  end
endmodule

// File: rtl/ptr_sub_flags_unit_chk.sv
module ptr_sub_flags_unit_chk
  import ptr_sub_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             out_valid_o,
  input logic [63:0]      res_o,
  input logic [IDX_W-1:0] rd_idx_o,
  input logic             rd_we_o,
  input logic [3:0]       flags_o,
  input logic             flags_we_o,
  input logic             undef_o,
  input logic             not_mine_o,
  input logic             cmp_alias_o
);
  a_r9_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !(out_valid_o || rd_we_o || flags_we_o || undef_o || not_mine_o || cmp_alias_o));
  a_r6_r8_no_write_on_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (undef_o || not_mine_o) |-> !(rd_we_o || flags_we_o));
  a_r8_exclusive_class: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(undef_o && not_mine_o));
  a_r7_zr_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_we_o |-> (rd_idx_o != SP_ZR_IDX) && flags_we_o);
  a_r7_alias_dest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_alias_o |-> (rd_idx_o == SP_ZR_IDX) && !not_mine_o);
  a_r5_nz_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_we_o |-> (flags_o[3] == res_o[63]) && (flags_o[2] == (res_o == 64'd0)));
  a_r10_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> !(out_valid_o || rd_we_o || flags_we_o));
endmodule

bind ptr_sub_flags_unit ptr_sub_flags_unit_chk u_chk (.*);

// File: tb/ptr_sub_flags_unit_tb.sv
module ptr_sub_flags_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic [63:0] rn_val_i = '0, rm_val_i = '0, sp_i = '0;
  logic        tag_en_i = 1'b1;
  logic        out_valid_o, rd_we_o, flags_we_o, undef_o, not_mine_o, cmp_alias_o;
  logic [63:0] res_o;
  logic [4:0]  rd_idx_o;
  logic [3:0]  flags_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  ptr_sub_flags_unit u_dut (.*);

  function automatic logic [31:0] enc(input logic [4:0] rm, input logic [4:0] rn, input logic [4:0] rd);
    return {11'b10111010110, rm, 6'd0, rn, rd};
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w, input logic [63:0] a, input logic [63:0] b,
                       input logic [63:0] sp, input logic en);
    @(negedge clk_i);
    insn_i = w; rn_val_i = a; rm_val_i = b; sp_i = sp; tag_en_i = en; in_valid_i = 1'b1;
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  // expected difference and flags from the requirement text
  task automatic chk_math(input string tag, input logic [63:0] x, input logic [63:0] y);
    logic [63:0] ex, ey, d;
    logic [3:0]  f;
    ex = {{8{x[55]}}, x[55:0]};
    ey = {{8{y[55]}}, y[55:0]};
    d  = ex - ey;
    f  = {d[63], d == 64'd0, ex >= ey, (ex[63] != ey[63]) && (d[63] != ex[63])};
    chk({tag, " res"}, res_o, d);
    chk({tag, " flags"}, {60'd0, flags_o}, {60'd0, f});
  endtask

  task automatic t_reset;
    chk("R10 reset valid", {63'd0, out_valid_o}, 64'd0);
    chk("R10 reset we", {62'd0, rd_we_o, flags_we_o}, 64'd0);
  endtask

  task automatic t_basic;
    issue(enc(5'd2, 5'd1, 5'd3), 64'd100, 64'd42, 64'd0, 1'b1);
    chk("R9 valid", {63'd0, out_valid_o}, 64'd1);
    chk_math("R4 basic", 64'd100, 64'd42);
    chk("R1 rd idx", {59'd0, rd_idx_o}, 64'd3);
    chk("R1 enables", {60'd0, rd_we_o, flags_we_o, undef_o, not_mine_o}, 64'b1100);
    issue(enc(5'd4, 5'd6, 5'd7), 64'd1, 64'd2, 64'd0, 1'b1);
    chk_math("R5 borrow", 64'd1, 64'd2);
    chk("R5 nzcv borrow", {60'd0, flags_o}, 64'b1000);
    issue(enc(5'd4, 5'd6, 5'd7), 64'h55, 64'h55, 64'd0, 1'b1);
    chk("R5 nzcv equal", {60'd0, flags_o}, 64'b0110);
  endtask

  task automatic t_sp;
    issue(enc(5'd1, 5'd31, 5'd3), 64'd999, 64'd10, 64'd500, 1'b1);
    chk_math("R2 sp first", 64'd500, 64'd10);
    issue(enc(5'd31, 5'd1, 5'd3), 64'd700, 64'd999, 64'd200, 1'b1);
    chk_math("R2 sp second", 64'd700, 64'd200);
  endtask

  task automatic t_tags;
    issue(enc(5'd1, 5'd2, 5'd3), 64'hAB00_0000_0000_0010, 64'h1200_0000_0000_0003, 64'd0, 1'b1);
    chk("R3 tags dropped", res_o, 64'hD);
    issue(enc(5'd1, 5'd2, 5'd3), 64'h0080_0000_0000_0000, 64'd0, 64'd0, 1'b1);
    chk("R3 sext", res_o, 64'hFF80_0000_0000_0000);
    chk("R3 sext flags", {60'd0, flags_o}, 64'b1010);
    issue(enc(5'd1, 5'd2, 5'd3), 64'h007F_FFFF_FFFF_FFFF, 64'h0080_0000_0000_0000, 64'd0, 1'b1);
    chk_math("R5 extreme", 64'h007F_FFFF_FFFF_FFFF, 64'h0080_0000_0000_0000);
  endtask

  task automatic t_undef;
    issue(enc(5'd1, 5'd2, 5'd3), 64'd9, 64'd1, 64'd0, 1'b0);
    chk("R6 undef", {60'd0, rd_we_o, flags_we_o, undef_o, not_mine_o}, 64'b0010);
  endtask

  task automatic t_zr;
    issue(enc(5'd1, 5'd2, 5'd31), 64'd9, 64'd1, 64'd0, 1'b1);
    chk("R7 zr dest", {60'd0, rd_we_o, flags_we_o, cmp_alias_o, not_mine_o}, 64'b0110);
    chk_math("R7 zr flags", 64'd9, 64'd1);
  endtask

  task automatic t_nomatch;
    issue(enc(5'd1, 5'd2, 5'd31) | 32'h0000_0400, 64'd9, 64'd1, 64'd0, 1'b1);
    chk("R8 bits15_10", {59'd0, rd_we_o, flags_we_o, undef_o, cmp_alias_o, not_mine_o}, 64'b00001);
    issue(enc(5'd1, 5'd2, 5'd3) ^ 32'h0020_0000, 64'd9, 64'd1, 64'd0, 1'b0);
    chk("R8 opcode", {59'd0, rd_we_o, flags_we_o, undef_o, cmp_alias_o, not_mine_o}, 64'b00001);
  endtask

  task automatic t_idle;
    issue(enc(5'd1, 5'd2, 5'd3), 64'd9, 64'd1, 64'd0, 1'b1);
    @(negedge clk_i);
    chk("R9 idle", {58'd0, out_valid_o, rd_we_o, flags_we_o, undef_o, cmp_alias_o, not_mine_o}, 64'd0);
  endtask

  task automatic t_async_reset;
    @(negedge clk_i);
    insn_i = enc(5'd1, 5'd2, 5'd3); tag_en_i = 1'b1; in_valid_i = 1'b1;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    #1 rst_ni = 1'b0;
    #0.5;
    chk("R10 async clear", {61'd0, out_valid_o, rd_we_o, flags_we_o}, 64'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_basic();
    t_sp();
    t_tags();
    t_undef();
    t_zr();
    t_nomatch();
    t_idle();
    t_async_reset();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R9 watchdog got=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule